// File: doc/BRIEF.md
# Rotating Register File with Base-Offset Renaming

This block holds a register array for software-pipelined loops and translates every logical register specifier into a physical register index before the array is accessed. Specifiers in the upper region of the register space are rotating. A movable base is added to them, modulo the size of that region. Specifiers in the lower region address the array directly and never move.

The base steps down by one on each loop-closing branch strobe, so every loop iteration sees a fresh set of rotating registers. A value written under specifier fN in one iteration can be read k iterations later under f(N+k). A schedule therefore encodes the latency of a producer as a difference between specifier numbers. A clear strobe returns the base to zero before a loop starts. The block takes any number of combinational read ports and one write port.

The base is kept by a two-state controller. **BASE_IDLE** is the reset and cleared state, in which the base is zero. **BASE_ROTATE** is the state while a loop runs. The transitions are:
- BASE_IDLE → BASE_ROTATE when a branch strobe arrives. The base becomes all ones.
- BASE_ROTATE → BASE_ROTATE when a branch strobe arrives. The base steps down by one.
- Any state → BASE_IDLE when the clear strobe arrives. The base becomes zero.

Clear takes priority over branch.

Top module: `rot_regfile`

## Requirements
- R1: After reset the base is zero and every specifier reads back zero data.
- R2: Specifiers 0 to 15 (the static region, with default parameters) map to the physical register of the same number whatever the base holds.
- R3: A specifier s in 16 to 31 maps to physical register 16 + ((s − 16 + base) mod 16).
- R4: Each branch strobe without clear lowers the base by one modulo 16, so a value written under fN is read under f(N+1) after one branch. With no strobe the base holds.
- R5: The clear strobe sets the base to zero in the next cycle, even when a branch strobe is asserted in the same cycle.
- R6: A write in the same cycle as a branch strobe is translated with the base value from before that update.
- R7: Reads are combinational and use the base of the current cycle. A write becomes visible from the cycle after its clock edge, so a same-cycle read returns the old content.
- R8: Each read port translates and reads its own specifier independently of the other ports.
- R9: Rotation wraps. A value written under f31 is read under f16 after one branch, and 16 branches bring the base back to its starting value.
- R10: While the write enable is low, no register changes, whatever appears on the write specifier and data inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rrb_clear | input | 1 | Sets the base to zero |
| loop_br | input | 1 | Strobe from the loop-closing branch; steps the base down |
| wr_en | input | 1 | Write enable |
| wr_spec | input | SPW (5) | Logical specifier for the write |
| wr_data | input | DW (32) | Write data |
| rd_spec | input | NRD*SPW (10) | Logical specifiers for the read ports, port p in bits [p*SPW +: SPW] |
| rd_data | output | NRD*DW (64) | Read data, port p in bits [p*DW +: DW] |

## Verification
The assertions assume that the branch and clear strobes are clean single-bit levels sampled at the clock edge. They also assume that the rotating region size is a power of two, so that the base wraps by plain binary arithmetic. The checks on the translator look only at read port 0 and rely on that port's specifier being stable around the sampling edge.

The bench drives every input on the falling edge and holds it until the next falling edge. It asserts strobes for exactly one rising edge at a time. It combines clear and branch only in the scenario that tests their priority.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    typedef enum logic {
        BASE_IDLE   = 1'b0,
        BASE_ROTATE = 1'b1
    } base_state_e;
endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl
    import rrf_pkg::*;
#(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [RW-1:0] base
);
    base_state_e state_q, state_d;
    logic [RW-1:0] base_d;

    // next state: clear wins, any branch strobe enters or stays in rotation
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BASE_IDLE:   if (!clear && step) state_d = BASE_ROTATE;
            BASE_ROTATE: if (clear)          state_d = BASE_IDLE;
            default:                         state_d = BASE_IDLE;
        endcase
    end

    // output: base value that the next cycle will see
    always_comb begin
        base_d = base;
        unique case (state_q)
            BASE_IDLE:   if (!clear && step) base_d = '1;
            BASE_ROTATE: begin
                if (clear)     base_d = '0;
                else if (step) base_d = base - RW'(1);
            end
            default:           base_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BASE_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base <= '0;
        else        base <= base_d;
    end
endmodule

// File: rtl/rrf_map.sv
module rrf_map #(
    parameter int NREG = 32,
    parameter int NROT = 16,
    localparam int SPW = $clog2(NREG),
    localparam int RW  = $clog2(NROT)
) (
    input  logic [SPW-1:0] spec,
    input  logic [RW-1:0]  base,
    output logic [SPW-1:0] phys
);
    localparam int LO = NREG - NROT;

    logic [SPW-1:0] off;
    logic [RW-1:0]  rot;

    always_comb begin
        off = spec - SPW'(LO);
        rot = off[RW-1:0] + base;
        if (spec >= SPW'(LO)) phys = SPW'(LO) + SPW'(rot);
        else                  phys = spec;
    end
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
    parameter int NREG = 32,
    parameter int NROT = 16,
    parameter int DW   = 32,
    parameter int NRD  = 2,
    localparam int SPW = $clog2(NREG),
    localparam int RW  = $clog2(NROT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rrb_clear,
    input  logic               loop_br,
    input  logic               wr_en,
    input  logic [SPW-1:0]     wr_spec,
    input  logic [DW-1:0]      wr_data,
    input  logic [NRD*SPW-1:0] rd_spec,
    output logic [NRD*DW-1:0]  rd_data
);
    logic [RW-1:0]      rrb;
    logic [SPW-1:0]     wr_phys;
    logic [NRD*SPW-1:0] rd_phys_flat;
    logic [DW-1:0]      mem [NREG];

    rrf_base_ctrl #(.RW(RW)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rrb_clear),
        .step  (loop_br),
        .base  (rrb)
    );

    // write translation uses the base before any same-cycle update
    rrf_map #(.NREG(NREG), .NROT(NROT)) u_wmap (
        .spec (wr_spec),
        .base (rrb),
        .phys (wr_phys)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rrf_map #(.NREG(NREG), .NROT(NROT)) u_rmap (
            .spec (rd_spec[p*SPW +: SPW]),
            .base (rrb),
            .phys (rd_phys_flat[p*SPW +: SPW])
        );
        assign rd_data[p*DW +: DW] = mem[rd_phys_flat[p*SPW +: SPW]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_phys] <= wr_data;
        end
    end
endmodule

// File: rtl/rrf_checker.sv
module rrf_checker #(
    parameter int NREG = 32,
    parameter int NROT = 16,
    localparam int SPW = $clog2(NREG),
    localparam int RW  = $clog2(NROT)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rrb_clear,
    input logic           loop_br,
    input logic [RW-1:0]  rrb,
    input logic [SPW-1:0] spec0,
    input logic [SPW-1:0] phys0
);
    localparam int LO = NREG - NROT;

    // R5: clear wins and zeroes the base
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rrb_clear |=> rrb == '0);

    // R4: branch lowers the base by one, modulo the region size
    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_br && !rrb_clear) |=> rrb == RW'($past(rrb) - RW'(1)));

    // R4: without a strobe the base holds
    p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_br && !rrb_clear) |=> $stable(rrb));

    // R2: the static region passes straight through
    p_static_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spec0 < SPW'(LO)) |-> phys0 == spec0);

    // R3: a rotating specifier never leaves the rotating region
    p_rot_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spec0 >= SPW'(LO)) |-> phys0 >= SPW'(LO));
endmodule

bind rot_regfile rrf_checker #(.NREG(NREG), .NROT(NROT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rrb_clear (rrb_clear),
    .loop_br   (loop_br),
    .rrb       (rrb),
    .spec0     (rd_spec[SPW-1:0]),
    .phys0     (rd_phys_flat[SPW-1:0])
);

// File: tb/tb_rot_regfile.sv
module tb_rot_regfile;
    localparam int PERIOD = 10;
    localparam int SPW = 5;
    localparam int DW  = 32;
    localparam int NRD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rrb_clear = 1'b0, loop_br = 1'b0, wr_en = 1'b0;
    logic [SPW-1:0] wr_spec = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [NRD*SPW-1:0] rd_spec = '0;
    logic [NRD*DW-1:0]  rd_data;

    int checks = 0;
    int errors = 0;

    rot_regfile dut (
        .clk(clk), .rst_n(rst_n), .rrb_clear(rrb_clear), .loop_br(loop_br),
        .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
        .rd_spec(rd_spec), .rd_data(rd_data)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic cmp(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock with the given inputs held across the rising edge
    task automatic cyc(input logic we, input logic [SPW-1:0] ws, input logic [DW-1:0] wd,
                       input logic br, input logic clr);
        @(negedge clk);
        wr_en = we; wr_spec = ws; wr_data = wd; loop_br = br; rrb_clear = clr;
        @(posedge clk); #1;
        wr_en = 1'b0; loop_br = 1'b0; rrb_clear = 1'b0;
    endtask

    task automatic wr(input logic [SPW-1:0] s, input logic [DW-1:0] d);
        cyc(1'b1, s, d, 1'b0, 1'b0);
    endtask
    task automatic br(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 1'b1, 1'b0);
    endtask
    task automatic clr();
        cyc(1'b0, '0, '0, 1'b0, 1'b1);
    endtask

    task automatic rd_chk(input int port, input logic [SPW-1:0] s,
                          input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        rd_spec[port*SPW +: SPW] = s;
        #1;
        cmp(rd_data[port*DW +: DW], exp, tag);
    endtask

    task automatic t_reset();
        for (int s = 0; s < 32; s++) rd_chk(s % 2, SPW'(s), '0, "R1 reset read");
    endtask

    task automatic t_static();
        clr(); wr(5'd3, 32'hA0A0_0003); br(3);
        rd_chk(1, 5'd3, 32'hA0A0_0003, "R2 static after branches");
    endtask

    task automatic t_rotate_step();
        clr(); wr(5'd20, 32'hB0B0_0020); br(1);
        rd_chk(0, 5'd21, 32'hB0B0_0020, "R4 f20 seen as f21");
    endtask

    task automatic t_absolute();
        clr(); br(5); wr(5'd16, 32'hC0C0_0027); clr();
        rd_chk(0, 5'd27, 32'hC0C0_0027, "R3 f16 at base 11 is phys 27");
    endtask

    task automatic t_clear_prio();
        clr(); br(2);
        cyc(1'b0, '0, '0, 1'b1, 1'b1);
        wr(5'd18, 32'hD0D0_0018); clr();
        rd_chk(0, 5'd18, 32'hD0D0_0018, "R5 clear beats branch");
    endtask

    task automatic t_write_on_branch();
        clr();
        cyc(1'b1, 5'd17, 32'hE0E0_0017, 1'b1, 1'b0);
        rd_chk(1, 5'd18, 32'hE0E0_0017, "R6 pre-update base on write");
        clr();
        rd_chk(0, 5'd17, 32'hE0E0_0017, "R6 phys 17 at base 0");
    endtask

    task automatic t_wrap();
        clr(); wr(5'd31, 32'h6060_0031); br(1);
        rd_chk(0, 5'd16, 32'h6060_0031, "R9 f31 wraps to f16");
        clr(); wr(5'd22, 32'h7070_0022); br(16);
        rd_chk(1, 5'd22, 32'h7070_0022, "R9 sixteen branches return");
    endtask

    task automatic t_two_ports();
        clr();
        @(negedge clk);
        rd_spec = {5'd27, 5'd3};
        #1;
        cmp(rd_data[DW-1:0],  32'hA0A0_0003, "R8 port0");
        cmp(rd_data[2*DW-1:DW], 32'hC0C0_0027, "R8 port1");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        rd_spec[SPW-1:0] = 5'd5;
        wr_en = 1'b1; wr_spec = 5'd5; wr_data = 32'hF0F0_0005;
        #1;
        cmp(rd_data[DW-1:0], '0, "R7 old value before edge");
        @(posedge clk); #1;
        wr_en = 1'b0;
        cmp(rd_data[DW-1:0], 32'hF0F0_0005, "R7 new value after edge");
    endtask

    task automatic t_no_write();
        cyc(1'b0, 5'd7, 32'hDEAD_BEEF, 1'b0, 1'b0);
        rd_chk(0, 5'd7, '0, "R10 disabled write ignored");
        rd_chk(1, 5'd3, 32'hA0A0_0003, "R10 other data intact");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_static();
        t_rotate_step();
        t_absolute();
        t_clear_prio();
        t_write_on_branch();
        t_wrap();
        t_two_ports();
        t_same_cycle();
        t_no_write();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule